// File: doc/BRIEF.md
# Dual PS/2 Port Register Front End

This block is the processor-facing register layer of a two-channel PS/2 controller, with one channel for a keyboard and one for a mouse. A simple single-beat register bus reaches two 256-byte windows. Address bit 8 picks the channel, and address bits [3:2] pick a register inside the window. Every channel exposes an identity code, a receive-data port, a control byte and a status byte.

Toward each device the block offers a byte receive side (data, not-empty flag, pop strobe), a transmit byte with a one-cycle strobe, and an interrupt-request input. The serial line engine sits outside this block.

Each channel has a private one-byte loopback buffer. With loopback on, a transmitted byte is held locally, shows up as received data and raises that channel's interrupt. No traffic reaches the device. A diagnostic mode makes the line-shadow status bits report the programmed line directions. The two channel interrupts are ORed onto one output.

Top module: `ps2_dual_regif`

## Requirements
- R1: Address bit 8 selects the channel (0 keyboard, 1 mouse) and only bits [3:2] select the register, so any address with bits [3:2] = 0 reads the identity code: 0 for the keyboard channel and 1 for the mouse channel.
- R2: A write to offset 8 stores the full byte as that channel's control value. A read of offset 8 returns the last stored value. The other channel's control value is unaffected.
- R3: Status bit 6 (data shadow) and status bit 7 (clock shadow) read 1, except when control bit 5 (diagnostic) is set. In that case bit 6 reads 0 when control bit 6 is clear, and bit 7 reads 0 when control bit 7 is clear.
- R4: With control bit 1 (loopback) set, a write to offset 4 stores the byte locally, sets status bit 0 and raises that channel's interrupt. No transmit strobe is produced.
- R5: With loopback set, a read of offset 4 returns the stored byte, clears status bit 0 and that channel's interrupt, and produces no receive pop.
- R6: Without loopback, a write to offset 4 pulses the transmit strobe for one cycle with the written byte. A read of offset 4 pulses the receive pop in the request cycle and returns the device byte. Status bit 0 equals the device not-empty flag.
- R7: Without loopback, a channel's interrupt follows its device request input. With loopback it follows only the loopback state. The interrupt output is the OR of both channels, and status bit 4 of either channel shows that OR.
- R8: Status bits 1, 2, 3 and 5 always read 0.
- R9: Reset clears both control bytes, the loopback buffers and flags, and the loopback interrupts. After reset, status reads 0xC0 plus the device not-empty flag.
- R10: Writes to offset 0 and offset 12 change no state and produce no strobe.
- R11: Read data is valid on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read request. Side effects of the read happen at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (9) | Byte address; bit 8 picks the channel, bits [3:2] the register |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_out | output | 1 | OR of both channel interrupts |
| kbd_rx_data | input | DATA_W (8) | Keyboard head-of-queue byte |
| kbd_rx_avail | input | 1 | Keyboard queue not empty |
| kbd_rx_pop | output | 1 | Keyboard queue pop |
| kbd_tx_data | output | DATA_W (8) | Keyboard transmit byte |
| kbd_tx_stb | output | 1 | Keyboard transmit strobe |
| kbd_irq_req | input | 1 | Keyboard device interrupt request |
| ms_rx_data | input | DATA_W (8) | Mouse head-of-queue byte |
| ms_rx_avail | input | 1 | Mouse queue not empty |
| ms_rx_pop | output | 1 | Mouse queue pop |
| ms_tx_data | output | DATA_W (8) | Mouse transmit byte |
| ms_tx_stb | output | 1 | Mouse transmit strobe |
| ms_irq_req | input | 1 | Mouse device interrupt request |

## Verification
The bench runs all four diagnostic and direction combinations through the shadow bits. A design that inverted or swapped the direction test would report the wrong line as driven. It fills and drains the mouse loopback buffer, expecting no pop or strobe toward the device and an interrupt that rises and falls. A design that leaked loopback traffic to the device, or left the interrupt stuck, is caught at the strobe ports and at `irq_out`. It also raises a device request while loopback is active and expects it masked, then drops loopback and expects the request to appear. Finally, it writes the reset and unmapped offsets and resets mid-state, which would expose stray control updates or loopback state that survives reset.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {
      OFS_ID   = 2'd0,
      OFS_DATA = 2'd1,
      OFS_CTRL = 2'd2,
      OFS_STAT = 2'd3
   } ofs_e;

   // control byte bit positions
   localparam int unsigned CB_EN   = 0;
   localparam int unsigned CB_LOOP = 1;
   localparam int unsigned CB_DIAG = 5;
   localparam int unsigned CB_DDIR = 6;
   localparam int unsigned CB_CDIR = 7;

   // status byte bit positions
   localparam int unsigned SB_RXNE = 0;
   localparam int unsigned SB_IRQ  = 4;
   localparam int unsigned SB_DSHD = 6;
   localparam int unsigned SB_CSHD = 7;
endpackage

// File: rtl/ps2r_stat.sv
module ps2r_stat
   import ps2r_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] ctrl,
   input  logic              rx_ne,
   input  logic              irq_any,
   output logic [DATA_W-1:0] stat
);
   logic diag;
   logic unused_ctrl;

   assign diag        = ctrl[CB_DIAG];
   assign unused_ctrl = ^{ctrl[CB_EN], ctrl[4:2]};

   generate
      if (DATA_W > BYTE_W) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^ctrl[DATA_W-1:BYTE_W];
      end
   endgenerate

   always_comb begin
      stat          = '0;
      stat[SB_RXNE] = rx_ne;
      stat[SB_IRQ]  = irq_any;
      stat[SB_DSHD] = !(diag && !ctrl[CB_DDIR]);
      stat[SB_CSHD] = !(diag && !ctrl[CB_CDIR]);
   end
endmodule

// File: rtl/ps2r_port.sv
module ps2r_port
   import ps2r_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned PORT_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  ofs_e              ofs,
   input  logic [DATA_W-1:0] wdata,
   input  logic              irq_any,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_avail,
   output logic              rx_pop,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_stb,
   input  logic              irq_req
);
   logic [DATA_W-1:0] ctrl_q, lb_buf_q, stat;
   logic              lb_full_q, lb_irq_q;
   logic              loop, wr_ctrl, wr_data, rd_data, rx_ne;

   assign loop    = ctrl_q[CB_LOOP];
   assign wr_ctrl = sel && we  && (ofs == OFS_CTRL);
   assign wr_data = sel && we  && (ofs == OFS_DATA);
   assign rd_data = sel && !we && (ofs == OFS_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         lb_buf_q  <= '0;
         lb_full_q <= 1'b0;
         lb_irq_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata;
         if (wr_data && loop) begin
            lb_buf_q  <= wdata;
            lb_full_q <= 1'b1;
            lb_irq_q  <= 1'b1;
         end else if (rd_data && loop) begin
            lb_full_q <= 1'b0;
            lb_irq_q  <= 1'b0;
         end
      end
   end

   assign tx_data = wdata;
   assign tx_stb  = wr_data && !loop;
   assign rx_pop  = rd_data && !loop;
   assign irq     = loop ? lb_irq_q : irq_req;
   assign rx_ne   = loop ? lb_full_q : rx_avail;

   ps2r_stat #(.DATA_W(DATA_W)) u_stat (
      .ctrl    (ctrl_q),
      .rx_ne   (rx_ne),
      .irq_any (irq_any),
      .stat    (stat)
   );

   always_comb begin
      unique case (ofs)
         OFS_ID:   rdata = DATA_W'(PORT_ID);
         OFS_DATA: rdata = loop ? lb_buf_q : rx_data;
         OFS_CTRL: rdata = ctrl_q;
         OFS_STAT: rdata = stat;
         default:  rdata = '0;
      endcase
   end

   // R4: loopback write fills the buffer and raises the interrupt
   p_lb_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && loop) |=> (lb_full_q && irq));

   // R5: loopback read drains the buffer
   p_lb_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && loop) |=> (!lb_full_q && !lb_irq_q));

   // R2: control changes only on a control write
   p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/ps2_dual_regif.sv
module ps2_dual_regif
   import ps2r_pkg::*;
#(
   parameter int unsigned ADDR_W    = 9,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned SEL_BIT   = 8,
   parameter bit          RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              irq_out,
   input  logic [DATA_W-1:0] kbd_rx_data,
   input  logic              kbd_rx_avail,
   output logic              kbd_rx_pop,
   output logic [DATA_W-1:0] kbd_tx_data,
   output logic              kbd_tx_stb,
   input  logic              kbd_irq_req,
   input  logic [DATA_W-1:0] ms_rx_data,
   input  logic              ms_rx_avail,
   output logic              ms_rx_pop,
   output logic [DATA_W-1:0] ms_tx_data,
   output logic              ms_tx_stb,
   input  logic              ms_irq_req
);
   localparam int unsigned NPORT = 2;

   generate
      if (DATA_W < BYTE_W) begin : g_bad_width
         $error("ps2_dual_regif: DATA_W must be at least 8");
      end
      if (SEL_BIT < 4 || SEL_BIT >= ADDR_W) begin : g_bad_sel
         $error("ps2_dual_regif: SEL_BIT must lie in [4, ADDR_W-1]");
      end
   endgenerate

   logic [DATA_W-1:0] rx_data_a [NPORT];
   logic [DATA_W-1:0] tx_data_a [NPORT];
   logic [DATA_W-1:0] rdata_a   [NPORT];
   logic [NPORT-1:0]  rx_avail_a, rx_pop_a, tx_stb_a, irq_req_a, irq_a, psel;
   logic              irq_any, rd_req, pidx;
   logic [DATA_W-1:0] rd_comb;
   ofs_e              ofs;
   logic              unused_addr;

   assign unused_addr = ^bus_addr;
   assign ofs         = ofs_e'(bus_addr[3:2]);
   assign pidx        = bus_addr[SEL_BIT];

   assign rx_data_a[0] = kbd_rx_data;
   assign rx_data_a[1] = ms_rx_data;
   assign rx_avail_a   = {ms_rx_avail, kbd_rx_avail};
   assign irq_req_a    = {ms_irq_req, kbd_irq_req};
   assign kbd_rx_pop   = rx_pop_a[0];
   assign ms_rx_pop    = rx_pop_a[1];
   assign kbd_tx_stb   = tx_stb_a[0];
   assign ms_tx_stb    = tx_stb_a[1];
   assign kbd_tx_data  = tx_data_a[0];
   assign ms_tx_data   = tx_data_a[1];

   assign irq_any = |irq_a;
   assign irq_out = irq_any;

   generate
      for (genvar i = 0; i < NPORT; i++) begin : g_port
         assign psel[i] = bus_sel && (pidx == 1'(i));
         ps2r_port #(.DATA_W(DATA_W), .PORT_ID(i)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (psel[i]),
            .we       (bus_we),
            .ofs      (ofs),
            .wdata    (bus_wdata),
            .irq_any  (irq_any),
            .rdata    (rdata_a[i]),
            .irq      (irq_a[i]),
            .rx_data  (rx_data_a[i]),
            .rx_avail (rx_avail_a[i]),
            .rx_pop   (rx_pop_a[i]),
            .tx_data  (tx_data_a[i]),
            .tx_stb   (tx_stb_a[i]),
            .irq_req  (irq_req_a[i])
         );
      end
   endgenerate

   assign rd_req  = bus_sel && !bus_we;
   assign rd_comb = pidx ? rdata_a[1] : rdata_a[0];

   generate
      if (RDATA_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         logic              rvalid_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rdata_q  <= '0;
               rvalid_q <= 1'b0;
            end else begin
               rdata_q  <= rd_req ? rd_comb : '0;
               rvalid_q <= rd_req;
            end
         end
         assign bus_rdata  = rdata_q;
         assign bus_rvalid = rvalid_q;

         // R11: every read request is answered in the following cycle
         p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
            rd_req |=> bus_rvalid);
      end else begin : g_rd_comb
         assign bus_rdata  = rd_req ? rd_comb : '0;
         assign bus_rvalid = rd_req;
      end
   endgenerate

   // R6: a single access produces at most one device-side strobe
   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_pop_a, tx_stb_a}));

   // R7: a keyboard request outside loopback reaches the shared output
   p_irq_dev_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kbd_irq_req && !g_port[0].u_port.loop) |-> irq_out);
endmodule

// File: tb/sim_ps2_dual_regif.sv
module sim_ps2_dual_regif;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [8:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_rvalid, irq_out;
   logic [7:0] kbd_rx_data = '0, ms_rx_data = '0;
   logic       kbd_rx_avail = 1'b0, ms_rx_avail = 1'b0;
   logic       kbd_irq_req = 1'b0, ms_irq_req = 1'b0;
   logic       kbd_rx_pop, ms_rx_pop, kbd_tx_stb, ms_tx_stb;
   logic [7:0] kbd_tx_data, ms_tx_data;

   int n_tests = 0, n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       s_ktx, s_mtx, s_kpop, s_mpop;
   logic [7:0] s_ktxd;

   always #5 clk = ~clk;

   ps2_dual_regif u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .irq_out(irq_out),
      .kbd_rx_data(kbd_rx_data), .kbd_rx_avail(kbd_rx_avail),
      .kbd_rx_pop(kbd_rx_pop), .kbd_tx_data(kbd_tx_data),
      .kbd_tx_stb(kbd_tx_stb), .kbd_irq_req(kbd_irq_req),
      .ms_rx_data(ms_rx_data), .ms_rx_avail(ms_rx_avail),
      .ms_rx_pop(ms_rx_pop), .ms_tx_data(ms_tx_data),
      .ms_tx_stb(ms_tx_stb), .ms_irq_req(ms_irq_req)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compares each returned read with the queued item
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected rvalid", bus_rdata, 8'h00);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            check(bus_rdata === e, t, bus_rdata, e);
         end
      end
   end

   task automatic sample_strobes();
      s_ktx  = kbd_tx_stb;
      s_mtx  = ms_tx_stb;
      s_kpop = kbd_rx_pop;
      s_mpop = ms_rx_pop;
      s_ktxd = kbd_tx_data;
   endtask

   task automatic do_write(input logic [8:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      #1 sample_strobes();
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic do_read(input logic [8:0] a, input logic [7:0] e,
                          input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      #1 sample_strobes();
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(irq_out === 1'b0, "R9 irq after reset", 8'(irq_out), 8'h00);
      check(bus_rvalid === 1'b0, "R11 idle rvalid", 8'(bus_rvalid), 8'h00);
      do_read(9'h00C, 8'hC0, "R9 reset status");
      do_read(9'h008, 8'h00, "R9 reset control");

      // identity and aliasing
      do_read(9'h000, 8'h00, "R1 kbd id");
      do_read(9'h100, 8'h01, "R1 mouse id");
      do_read(9'h0F0, 8'h00, "R1 id alias");

      // control storage
      do_write(9'h008, 8'h81);
      do_read(9'h008, 8'h81, "R2 ctrl readback");
      do_read(9'h108, 8'h00, "R2 other ctrl untouched");

      // ignored writes
      do_write(9'h000, 8'hFF);
      check(!s_ktx && !s_mtx, "R10 no strobe on offset 0", 8'(s_ktx), 8'h00);
      do_write(9'h00C, 8'h55);
      check(!s_ktx && !s_mtx, "R10 no strobe on offset 12", 8'(s_ktx), 8'h00);
      do_read(9'h008, 8'h81, "R10 ctrl unchanged");

      // shadow bits in diagnostic mode
      do_write(9'h008, 8'h20);
      do_read(9'h00C, 8'h00, "R3 diag both dirs clear");
      do_write(9'h008, 8'h60);
      do_read(9'h00C, 8'h40, "R3 diag data dir set");
      do_write(9'h008, 8'hA0);
      do_read(9'h00C, 8'h80, "R3 diag clock dir set");
      do_write(9'h008, 8'hE0);
      do_read(9'h00C, 8'hC0, "R3 diag both dirs set");
      do_write(9'h008, 8'hC0);
      do_read(9'h00C, 8'hC0, "R3 dirs without diag");

      // normal receive and transmit
      kbd_rx_avail = 1'b1; kbd_rx_data = 8'h5A;
      do_write(9'h008, 8'h01);
      do_read(9'h00C, 8'hC1, "R6 status rx not empty");
      do_read(9'h00C, 8'hC1, "R8 reserved status bits zero");
      do_read(9'h004, 8'h5A, "R6 rx data");
      check(s_kpop && !s_mpop, "R6 kbd pop", 8'(s_kpop), 8'h01);
      do_write(9'h004, 8'hED);
      check(s_ktx && !s_mtx, "R6 kbd tx strobe", 8'(s_ktx), 8'h01);
      check(s_ktxd === 8'hED, "R6 kbd tx data", s_ktxd, 8'hED);

      // device interrupt path
      kbd_irq_req = 1'b1;
      #1 check(irq_out === 1'b1, "R7 irq follows kbd req", 8'(irq_out), 8'h01);
      do_read(9'h10C, 8'hD0, "R7 combined bit in mouse status");
      kbd_irq_req = 1'b0;
      #1 check(irq_out === 1'b0, "R7 irq drops", 8'(irq_out), 8'h00);

      // mouse loopback
      do_write(9'h108, 8'h02);
      do_write(9'h104, 8'h3C);
      check(!s_mtx && !s_ktx, "R4 no tx strobe in loopback", 8'(s_mtx), 8'h00);
      #1 check(irq_out === 1'b1, "R4 loopback irq", 8'(irq_out), 8'h01);
      do_read(9'h10C, 8'hD1, "R4 loopback status");
      do_read(9'h00C, 8'hD1, "R7 kbd sees combined irq");
      do_read(9'h104, 8'h3C, "R5 loopback data");
      check(!s_mpop && !s_kpop, "R5 no pop in loopback", 8'(s_mpop), 8'h00);
      #1 check(irq_out === 1'b0, "R5 irq cleared", 8'(irq_out), 8'h00);
      do_read(9'h10C, 8'hC0, "R5 status drained");

      // device request masked during loopback
      ms_irq_req = 1'b1;
      #1 check(irq_out === 1'b0, "R7 req masked in loopback", 8'(irq_out), 8'h00);
      do_write(9'h108, 8'h00);
      #1 check(irq_out === 1'b1, "R7 req visible after loopback", 8'(irq_out), 8'h01);
      ms_irq_req = 1'b0;

      // reset with state present
      do_write(9'h008, 8'h22);
      do_write(9'h108, 8'h02);
      do_write(9'h104, 8'h99);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1 check(irq_out === 1'b0, "R9 irq cleared by reset", 8'(irq_out), 8'h00);
      do_read(9'h008, 8'h00, "R9 kbd ctrl cleared");
      do_read(9'h00C, 8'hC1, "R9 kbd status after reset");
      do_read(9'h10C, 8'hC0, "R9 mouse loopback cleared");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R11 all reads answered", 8'(exp_q.size()), 8'h00);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule